// File: doc/BRIEF.md
# Neutral-Point Balance Duty Adjuster

This block sits between a three-phase duty-cycle generator and a single-carrier PWM comparator stage of a three-level inverter. Each phase delivers an upper and a lower duty word; the block moves duty between them by a signed correction so that the two halves of the split dc link stay at equal voltage. The correction comes from a small PI regulator. The regulator acts on the difference between the two sampled capacitor voltages, upper minus lower.

A positive correction is taken first from the lower word. Any part that the lower word cannot absorb is then taken from the upper word. A negative correction is taken first from the upper word, and any remainder is added to the lower word. The regulator state and the output words update once per carrier period, on a strobe. With no imbalance and a cleared integrator, the words pass through unchanged.

Top module: `np_balance_adj`

## Requirements
- R1: On each strobe the correction is off = clamp(floor((kp*e + I) / 2^FRAC_W), -LIM, +LIM). Here e = vcap_hi_i - vcap_lo_i, I is the integrator after its update on that strobe, FS = 2^DW - 1 and LIM = floor(FS/4).
- R2: On each strobe the integrator becomes clamp(I + ki*e, -LIM*2^FRAC_W, +LIM*2^FRAC_W), which bounds windup. Between strobes it holds.
- R3: When off >= 0 and lower >= off, the upper word passes unchanged and the lower word becomes lower - off.
- R4: When off >= 0 and lower < off, the lower word becomes 0 and the upper word becomes upper - (off - lower), floored at 0.
- R5: When off < 0 and upper >= |off|, the upper word becomes upper - |off| and the lower word passes unchanged.
- R6: When off < 0 and upper < |off|, the upper word becomes 0 and the lower word becomes lower + (|off| - upper), capped at FS.
- R7: The rules apply to each phase independently, using the one shared correction. Phase k occupies bits [k*DW +: DW] of every packed duty port, for k = 0, 1, 2.
- R8: valid_o is high for exactly one cycle, two rising edges after the edge that samples strobe_i. The output words change only together with that pulse and hold otherwise.
- R9: With e = 0 and a zero integrator, every output word equals its input word bit for bit.
- R10: While reset is asserted, all output words are 0, valid_o is 0 and the integrator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Once-per-carrier-period update strobe |
| duty_up_i | input | 3*DW | Upper duty words, packed by phase |
| duty_lo_i | input | 3*DW | Lower duty words, packed by phase |
| vcap_hi_i | input | VW | Upper capacitor voltage sample, unsigned |
| vcap_lo_i | input | VW | Lower capacitor voltage sample, unsigned |
| kp_i | input | 16 | Proportional gain, signed, FRAC_W fraction bits |
| ki_i | input | 16 | Integral gain, signed, FRAC_W fraction bits |
| duty_up_o | output | 3*DW | Adjusted upper duty words |
| duty_lo_o | output | 3*DW | Adjusted lower duty words |
| valid_o | output | 1 | One-cycle pulse marking new output words |

## Verification
The bench builds the block with DW = 6, VW = 4 and FRAC_W = 2. That gives a full scale of 63, a correction limit of 15 and an integrator limit of 60. With kp = 4 and ki = 0, the correction equals the voltage difference exactly. Every correction from -15 to +15 can therefore be applied across all 64 upper values and a spread of lower values, which reaches each branch, both saturation corners and the exact-equality boundaries. The small integrator limit lets a few strobes drive the regulator into its windup clamp and back out, so the anti-windup recovery can be observed through the lower duty word.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;
  localparam int GAIN_W = 16;

  function automatic int lim_of(input int dw);
    return ((1 << dw) - 1) >> 2;
  endfunction
endpackage

// File: rtl/np_pi_reg.sv
module np_pi_reg
  import np_bal_pkg::*;
#(
  parameter int DW     = 12,
  parameter int VW     = 10,
  parameter int FRAC_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      strobe_i,
  input  logic [VW-1:0]             vhi_i,
  input  logic [VW-1:0]             vlo_i,
  input  logic signed [GAIN_W-1:0]  kp_i,
  input  logic signed [GAIN_W-1:0]  ki_i,
  output logic signed [DW:0]        off_o
);
  localparam int EW   = VW + 1;
  localparam int PW   = GAIN_W + EW;
  localparam int AW   = PW + DW + FRAC_W + 2;
  localparam int OW   = DW + 1;
  localparam int LIM  = lim_of(DW);
  localparam int ILIM = LIM << FRAC_W;

  logic signed [EW-1:0] err;
  logic signed [PW-1:0] p_term, i_term;
  logic signed [AW-1:0] acc_sum, acc_nxt, tot, shf, integ_q;
  logic signed [OW-1:0] off_nxt;

  assign err    = $signed({1'b0, vhi_i}) - $signed({1'b0, vlo_i});
  assign p_term = PW'(kp_i) * PW'(err);
  assign i_term = PW'(ki_i) * PW'(err);

  always_comb begin
    acc_sum = integ_q + AW'(i_term);
    if (acc_sum > AW'(ILIM))       acc_nxt = AW'(ILIM);
    else if (acc_sum < AW'(-ILIM)) acc_nxt = AW'(-ILIM);
    else                           acc_nxt = acc_sum;
    tot = acc_nxt + AW'(p_term);
    shf = tot >>> FRAC_W;
    if (shf > AW'(LIM))       off_nxt = OW'(LIM);
    else if (shf < AW'(-LIM)) off_nxt = OW'(-LIM);
    else                      off_nxt = shf[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      off_o   <= '0;
    end else if (strobe_i) begin
      integ_q <= acc_nxt;
      off_o   <= off_nxt;
    end
  end

  assert_offset_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_o <= OW'(LIM)) && (off_o >= OW'(-LIM)));
  assert_integ_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_q <= AW'(ILIM)) && (integ_q >= AW'(-ILIM)));
  assert_integ_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(integ_q));
endmodule

// File: rtl/np_phase_adj.sv
module np_phase_adj #(
  parameter int DW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DW-1:0]      up_i,
  input  logic [DW-1:0]      lo_i,
  input  logic signed [DW:0] off_i,
  output logic [DW-1:0]      up_o,
  output logic [DW-1:0]      lo_o
);
  localparam logic [DW:0] FS = {1'b0, {DW{1'b1}}};

  logic [DW:0] up_x, lo_x, mag, rem, sum;
  logic [DW-1:0] nu, nl;

  assign up_x = {1'b0, up_i};
  assign lo_x = {1'b0, lo_i};
  assign mag  = off_i[DW] ? DW'(-off_i) : off_i;

  always_comb begin
    nu  = up_i;
    nl  = lo_i;
    rem = '0;
    sum = '0;
    if (!off_i[DW]) begin
      if (lo_x >= mag) begin
        nl = DW'(lo_x - mag);
      end else begin
        rem = mag - lo_x;
        nl  = '0;
        nu  = (rem > up_x) ? '0 : DW'(up_x - rem);
      end
    end else begin
      if (up_x >= mag) begin
        nu = DW'(up_x - mag);
      end else begin
        rem = mag - up_x;
        nu  = '0;
        sum = lo_x + rem;
        nl  = (sum > FS) ? FS[DW-1:0] : sum[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= '0;
      lo_o <= '0;
    end else if (en_i) begin
      up_o <= nu;
      lo_o <= nl;
    end
  end

  assert_pos_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !off_i[DW]) |=> (up_o <= $past(up_i)) && (lo_o <= $past(lo_i)));
  assert_neg_shifts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && off_i[DW]) |=> (up_o <= $past(up_i)) && (lo_o >= $past(lo_i)));
  assert_zero_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && off_i == '0) |=> (up_o == $past(up_i)) && (lo_o == $past(lo_i)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(up_o) && $stable(lo_o));
endmodule

// File: rtl/np_balance_adj.sv
module np_balance_adj
  import np_bal_pkg::*;
#(
  parameter int DW     = 12,
  parameter int VW     = 10,
  parameter int FRAC_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [3*DW-1:0]          duty_up_i,
  input  logic [3*DW-1:0]          duty_lo_i,
  input  logic [VW-1:0]            vcap_hi_i,
  input  logic [VW-1:0]            vcap_lo_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  output logic [3*DW-1:0]          duty_up_o,
  output logic [3*DW-1:0]          duty_lo_o,
  output logic                     valid_o
);
  localparam int NPH = 3;

  logic signed [DW:0]    off;
  logic [NPH*DW-1:0]     up_a, lo_a;
  logic                  val_a;

  np_pi_reg #(.DW(DW), .VW(VW), .FRAC_W(FRAC_W)) u_pi (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .vhi_i(vcap_hi_i), .vlo_i(vcap_lo_i),
    .kp_i(kp_i), .ki_i(ki_i), .off_o(off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_a    <= '0;
      lo_a    <= '0;
      val_a   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      val_a   <= strobe_i;
      valid_o <= val_a;
      if (strobe_i) begin
        up_a <= duty_up_i;
        lo_a <= duty_lo_i;
      end
    end
  end

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    np_phase_adj #(.DW(DW)) u_ph (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(val_a),
      .up_i(up_a[k*DW +: DW]), .lo_i(lo_a[k*DW +: DW]), .off_i(off),
      .up_o(duty_up_o[k*DW +: DW]), .lo_o(duty_lo_o[k*DW +: DW])
    );
  end

  assert_valid_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(strobe_i, 2));
endmodule

// File: tb/tb_np_balance_adj.sv
module tb_np_balance_adj;
  localparam int DW = 6, VW = 4, FRAC_W = 2;
  localparam int FS = (1 << DW) - 1;
  localparam int LIM = FS >> 2;
  localparam int ILIM = LIM << FRAC_W;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [3*DW-1:0] up_i = '0, lo_i = '0;
  logic [3*DW-1:0] up_o, lo_o;
  logic [VW-1:0] vhi = '0, vlo = '0;
  logic signed [15:0] kp = '0, ki = '0;
  logic valid;
  int n_chk = 0, n_bad = 0, integ_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  np_balance_adj #(.DW(DW), .VW(VW), .FRAC_W(FRAC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe),
    .duty_up_i(up_i), .duty_lo_i(lo_i), .vcap_hi_i(vhi), .vcap_lo_i(vlo),
    .kp_i(kp), .ki_i(ki), .duty_up_o(up_o), .duty_lo_o(lo_o), .valid_o(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lim);
    return (v > lim) ? lim : ((v < -lim) ? -lim : v);
  endfunction

  function automatic string tag_of(input int lo, input int up, input int off);
    if (off == 0) return "R9 R7";
    if (off > 0) return (lo >= off) ? "R3 R7" : "R4 R7";
    return (up >= -off) ? "R5 R7" : "R6 R7";
  endfunction

  function automatic void model(input int up, input int lo, input int off,
                                output int nu, output int nl);
    int r;
    nu = up; nl = lo;
    if (off >= 0) begin
      if (lo < off) begin
        r = off - lo; nl = 0; nu = (r > up) ? 0 : up - r;
      end else nl = lo - off;
    end else begin
      if (up < -off) begin
        r = -off - up; nu = 0; nl = (lo + r > FS) ? FS : lo + r;
      end else nu = up + off;
    end
  endfunction

  task automatic run(input int kpv, input int kiv, input int vh, input int vl,
                     input int u0, input int l0, input int u1, input int l1,
                     input int u2, input int l2, input string pre);
    int e, off, u[3], l[3], eu, el;
    u[0] = u0; u[1] = u1; u[2] = u2; l[0] = l0; l[1] = l1; l[2] = l2;
    e = vh - vl;
    integ_m = clampi(integ_m + kiv * e, ILIM);
    off = clampi((kpv * e + integ_m) >>> FRAC_W, LIM);
    kp = 16'(kpv); ki = 16'(kiv); vhi = VW'(vh); vlo = VW'(vl);
    for (int k = 0; k < 3; k++) begin
      up_i[k*DW +: DW] = DW'(u[k]);
      lo_i[k*DW +: DW] = DW'(l[k]);
    end
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    chk("R8 valid pulse", int'(valid), 1);
    for (int k = 0; k < 3; k++) begin
      model(u[k], l[k], off, eu, el);
      chk({pre, tag_of(l[k], u[k], off), " upper"}, int'(up_o[k*DW +: DW]), eu);
      chk({pre, tag_of(l[k], u[k], off), " lower"}, int'(lo_o[k*DW +: DW]), el);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int last_u, last_l;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", int'(valid), 0);
    chk("R10 upper", int'(up_o), 0);
    chk("R10 lower", int'(lo_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after release", int'(valid), 0);

    // R3..R7, R9: every correction via kp = 2^FRAC_W, ki = 0
    for (int e = -LIM; e <= LIM; e++) begin
      for (int a = 0; a <= FS; a++) begin
        for (int b = 0; b <= FS; b += 7) begin
          run(1 << FRAC_W, 0, (e > 0) ? e : 0, (e < 0) ? -e : 0,
              a, b, FS - a, b, a, FS - b, "");
        end
      end
    end

    // R8: outputs hold and valid drops between strobes
    last_u = int'(up_o); last_l = int'(lo_o);
    @(negedge clk);
    chk("R8 valid low", int'(valid), 0);
    chk("R8 upper held", int'(up_o), last_u);
    chk("R8 lower held", int'(lo_o), last_l);
    vhi = VW'(9); vlo = '0; up_i = '1; lo_i = '0;
    repeat (3) @(negedge clk);
    chk("R8 no strobe upper", int'(up_o), last_u);
    chk("R8 no strobe lower", int'(lo_o), last_l);

    // R1, R2: integral accumulation, windup clamp and recovery
    for (int n = 0; n < 25; n++) run(0, 1, 3, 0, 40, 63, 20, 30, 5, 10, "R1 R2 ");
    for (int n = 0; n < 4; n++)  run(0, 4, 15, 0, 40, 63, 20, 30, 5, 10, "R2 windup ");
    for (int n = 0; n < 20; n++) run(0, 4, 0, 1, 40, 63, 20, 30, 5, 10, "R2 recover ");
    for (int n = 0; n < 6; n++)  run(0, 5, 0, 15, 8, 50, 63, 0, 30, 60, "R2 neg clamp ");
    for (int kv = -3; kv <= 3; kv++) begin
      for (int iv = -2; iv <= 2; iv++) begin
        for (int e = -6; e <= 6; e += 3) begin
          run(kv * 3, iv, (e > 0) ? e : 0, (e < 0) ? -e : 0,
              12, 9, 60, 2, 1, 55, "R1 R2 mix ");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule